// File: doc/BRIEF.md
# Partitionable Timer/Counter with Capture

This block is a 16-bit count chain that can be split into two 8-bit halves or used whole. A shared programmable prescaler turns the instruction-cycle enable into timer ticks, and an external event pin can replace the prescaler as the count source. Which source drives each half, and whether the halves are chained, is set by a 2-bit mode input. Two capture strobes copy the live count into capture registers. Each half compares its count with a match value. On a match the half wraps to zero and raises a one-clock flag, which the interrupt logic treats as a request.

All state moves only on clocks where the instruction-cycle enable is high. The event pin and both strobe pins are sampled at those ticks through a two-stage synchroniser and a rising-edge detector. As a result, a level must be held for at least one full instruction cycle to be recognised.

Top module: `split_timer_cap`

## Requirements
- R1: After reset, both counts, both capture registers and both flags read zero.
- R2: The event and strobe pins are sampled only on ticks (clocks with `cyc_en` high). A rising level first affects the counts or captures on the third tick after the pin rises. A pulse that rises and falls between two ticks has no effect.
- R3: With reload value P, a prescaled count advances once every P+1 ticks. A new `pre_reload` value is loaded only when the prescaler wraps, or while no prescaled half is running.
- R4: Mode 0 (`mode`=2'b00): the low and high halves are independent 8-bit timers on the prescaler. `run_lo` gates the low half and `run_hi` gates the high half.
- R5: Mode 1 (`mode`=2'b01): the low half is a prescaled 8-bit timer gated by `run_lo`. The high half counts rising edges of `evt_pin` and is gated by `run_hi`.
- R6: Mode 2 (`mode`=2'b10): `{cnt_hi,cnt_lo}` is one 16-bit prescaled timer gated by `run_hi`, with a carry from the low byte into the high byte. It matches against `{match_hi,match_lo}`, and only `flag_hi` can rise.
- R7: Mode 3 (`mode`=2'b11): `{cnt_hi,cnt_lo}` is one 16-bit counter of `evt_pin` rising edges, gated by `run_hi`, and it matches against `{match_hi,match_lo}`.
- R8: When a half (or the 16-bit chain) advances while its count equals its match value, the count becomes zero. The corresponding flag is then high for exactly one clock.
- R9: In modes 0 and 1, a recognised rising edge on `cap_lo_pin` copies the low count held before that tick into `cap_lo`. A recognised edge on `cap_hi_pin` does the same for the high count into `cap_hi`.
- R10: In modes 2 and 3, a recognised `cap_hi_pin` edge copies the full 16-bit count into `{cap_hi,cap_lo}`, and `cap_lo_pin` has no effect.
- R11: A tick with a mode different from the previous tick's mode, or a tick with a half's run enable low, clears that count and the prescaler. The capture registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock pulse per instruction cycle |
| evt_pin | input | 1 | External event input (asynchronous) |
| cap_lo_pin | input | 1 | Low capture strobe (asynchronous) |
| cap_hi_pin | input | 1 | High capture strobe (asynchronous) |
| mode | input | 2 | Partition mode 0..3 |
| run_lo | input | 1 | Low half run enable |
| run_hi | input | 1 | High half / 16-bit run enable |
| match_lo | input | 8 | Low match value |
| match_hi | input | 8 | High match value |
| pre_reload | input | 8 | Prescaler reload value |
| cnt_lo | output | 8 | Low count |
| cnt_hi | output | 8 | High count |
| cap_lo | output | 8 | Low capture register |
| cap_hi | output | 8 | High capture register |
| flag_lo | output | 1 | Low match flag |
| flag_hi | output | 1 | High / 16-bit match flag |

## Verification
Every result is registered on the clock where `cyc_en` is high. Counts, captures and flags are therefore due one clock after the tick that causes them. The effect of a pin rise is due on the third tick after the pin rises, because of the two synchroniser stages and the edge stage. The bench drives one tick every three clocks. On each tick it pushes the expected outputs from a tick-level model into a queue. The monitor pops that entry at the falling edge right after the tick clock, and one clock later it confirms that both flags have dropped. Short pin pulses are placed between ticks, so an effect from them would show up in the next compared entry.

// File: rtl/split_timer_cap_pkg.sv
package split_timer_cap_pkg;

    parameter int unsigned HALF_W = 8;
    localparam int unsigned FULL_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        MODE_SPLIT    = 2'b00,
        MODE_MIXED    = 2'b01,
        MODE_WIDE_TMR = 2'b10,
        MODE_WIDE_EVT = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] cap_lo;
        logic [HALF_W-1:0] cap_hi;
        logic              flag_lo;
        logic              flag_hi;
        tmr_mode_e         mode;
    } top_state_t;

    localparam int unsigned PIN_EVT   = 0;
    localparam int unsigned PIN_CAPLO = 1;
    localparam int unsigned PIN_CAPHI = 2;
    localparam int unsigned PIN_NUM   = 3;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic rise
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] shift_d, shift_q;

    always_comb begin
        shift_d = shift_q;
        if (tick) begin
            shift_d = {shift_q[LEN-2:0], pin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_d;
        end
    end

    assign rise = shift_q[LEN-2] & ~shift_q[LEN-1];

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       at_lim;

    always_comb begin
        st_d   = st_q;
        at_lim = (st_q.cnt == st_q.lim);
        wrap   = tick & run & at_lim;
        if (tick) begin
            if (!run || at_lim) begin
                st_d.cnt = '0;
                st_d.lim = reload;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         inc,
    input  logic         to_zero,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            if (clr) begin
                cnt_d = '0;
            end else if (inc) begin
                cnt_d = to_zero ? '0 : cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/split_timer_cap.sv
module split_timer_cap
    import split_timer_cap_pkg::*;
#(
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              evt_pin,
    input  logic              cap_lo_pin,
    input  logic              cap_hi_pin,
    input  logic [1:0]        mode,
    input  logic              run_lo,
    input  logic              run_hi,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    input  logic [PRE_W-1:0]  pre_reload,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    logic [PIN_NUM-1:0] pins, rises;

    assign pins[PIN_EVT]   = evt_pin;
    assign pins[PIN_CAPLO] = cap_lo_pin;
    assign pins[PIN_CAPHI] = cap_hi_pin;

    for (genvar g = 0; g < PIN_NUM; g++) begin : g_sync
        tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (cyc_en),
            .pin  (pins[g]),
            .rise (rises[g])
        );
    end

    top_state_t st_d, st_q;

    logic wide, mode_chg, pre_run, pre_wrap;
    logic lo_run, lo_src, hi_src, lo_adv, hi_adv8;
    logic lo_clr, hi_clr, lo_inc, hi_inc, lo_zero, hi_zero;
    logic lo_eq, hi_eq, full_eq, lo_max;

    tmr_prescaler #(.W(PRE_W)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_en),
        .run   (pre_run),
        .reload(pre_reload),
        .wrap  (pre_wrap)
    );

    tmr_half #(.W(HALF_W)) i_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cyc_en),
        .clr    (lo_clr),
        .inc    (lo_inc),
        .to_zero(lo_zero),
        .cnt    (cnt_lo)
    );

    tmr_half #(.W(HALF_W)) i_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cyc_en),
        .clr    (hi_clr),
        .inc    (hi_inc),
        .to_zero(hi_zero),
        .cnt    (cnt_hi)
    );

    // partition and counter steering
    always_comb begin
        wide     = mode[1];
        mode_chg = (mode != st_q.mode);
        unique case (mode)
            MODE_SPLIT:    pre_run = run_lo | run_hi;
            MODE_MIXED:    pre_run = run_lo;
            MODE_WIDE_TMR: pre_run = run_hi;
            default:       pre_run = 1'b0;
        endcase
        pre_run = pre_run & ~mode_chg;

        lo_run  = wide ? run_hi : run_lo;
        lo_src  = (mode == MODE_WIDE_EVT) ? rises[PIN_EVT] : pre_wrap;
        hi_src  = mode[0] ? rises[PIN_EVT] : pre_wrap;
        lo_adv  = lo_run & lo_src;
        hi_adv8 = run_hi & hi_src;
        lo_clr  = mode_chg | ~lo_run;
        hi_clr  = mode_chg | ~run_hi;

        lo_eq   = (cnt_lo == match_lo);
        hi_eq   = (cnt_hi == match_hi);
        full_eq = lo_eq & hi_eq;
        lo_max  = &cnt_lo;

        if (wide) begin
            lo_inc  = lo_adv;
            lo_zero = full_eq;
            hi_inc  = lo_adv & (lo_max | full_eq);
            hi_zero = full_eq;
        end else begin
            lo_inc  = lo_adv;
            lo_zero = lo_eq;
            hi_inc  = hi_adv8;
            hi_zero = hi_eq;
        end
    end

    // flags, captures and mode history
    always_comb begin
        st_d         = st_q;
        st_d.flag_lo = cyc_en & ~wide & ~lo_clr & lo_inc & lo_eq;
        st_d.flag_hi = cyc_en & ~hi_clr &
                       (wide ? (lo_inc & full_eq) : (hi_inc & hi_eq));
        if (cyc_en) begin
            st_d.mode = tmr_mode_e'(mode);
            if (wide) begin
                if (rises[PIN_CAPHI]) begin
                    st_d.cap_hi = cnt_hi;
                    st_d.cap_lo = cnt_lo;
                end
            end else begin
                if (rises[PIN_CAPLO]) st_d.cap_lo = cnt_lo;
                if (rises[PIN_CAPHI]) st_d.cap_hi = cnt_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cap_lo: '0, cap_hi: '0, flag_lo: 1'b0,
                      flag_hi: 1'b0, mode: MODE_SPLIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_lo  = st_q.cap_lo;
    assign cap_hi  = st_q.cap_hi;
    assign flag_lo = st_q.flag_lo;
    assign flag_hi = st_q.flag_hi;

endmodule

// File: rtl/split_timer_cap_chk.sv
module split_timer_cap_chk
    import split_timer_cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_en,
    input logic [1:0]        mode,
    input logic              run_lo,
    input logic              run_hi,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cap_lo,
    input logic [HALF_W-1:0] cap_hi,
    input logic              flag_lo,
    input logic              flag_hi
);
    // R8
    flag_lo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_lo |=> !flag_lo);

    // R8
    flag_hi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hi |=> !flag_hi);

    // R8
    flag_hi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hi |-> (cnt_hi == '0) && $past(cyc_en));

    // R6
    no_lo_flag_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_lo |-> !$past(mode[1]));

    // R9
    cap_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(cap_lo) && $stable(cap_hi));

    // R11
    run_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !run_lo && !run_hi) |=> (cnt_lo == '0) && (cnt_hi == '0));

endmodule

bind split_timer_cap split_timer_cap_chk i_chk (.*);

// File: tb/test_split_timer_cap.sv
module test_split_timer_cap;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       evt_pin = 1'b0, cap_lo_pin = 1'b0, cap_hi_pin = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       run_lo = 1'b0, run_hi = 1'b0;
    logic [7:0] match_lo = '0, match_hi = '0, pre_reload = '0;
    logic [7:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
    logic       flag_lo, flag_hi;

    split_timer_cap i_split_timer_cap (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] lo, hi, clo, chi;
        logic       fl, fh;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // tick-level reference state
    logic [2:0] m_evt = '0, m_clo_s = '0, m_chi_s = '0;
    logic [7:0] m_pc = '0, m_pl = '0, m_lo = '0, m_hi = '0, m_clo = '0, m_chi = '0;
    logic [1:0] m_mode = '0;

    task automatic tick(input string tag);
        exp_t e;
        logic ev, ecl, ech, mchg, prun, ptick, fl, fh, adv;
        logic [15:0] v;
        ev   = m_evt[1] & ~m_evt[2];
        ecl  = m_clo_s[1] & ~m_clo_s[2];
        ech  = m_chi_s[1] & ~m_chi_s[2];
        mchg = (mode != m_mode);
        case (mode)
            2'd0: prun = run_lo | run_hi;
            2'd1: prun = run_lo;
            2'd2: prun = run_hi;
            default: prun = 1'b0;
        endcase
        prun  = prun & ~mchg;
        ptick = 1'b0;
        if (!prun) begin
            m_pc = '0; m_pl = pre_reload;
        end else if (m_pc == m_pl) begin
            ptick = 1'b1; m_pc = '0; m_pl = pre_reload;
        end else begin
            m_pc = m_pc + 8'd1;
        end
        fl = 1'b0; fh = 1'b0;
        if (mode[1]) begin
            if (ech) begin m_chi = m_hi; m_clo = m_lo; end
            v = {m_hi, m_lo};
            if (mchg || !run_hi) v = '0;
            else begin
                adv = (mode == 2'd2) ? ptick : ev;
                if (adv) begin
                    if (v == {match_hi, match_lo}) begin v = '0; fh = 1'b1; end
                    else v = v + 16'd1;
                end
            end
            {m_hi, m_lo} = v;
        end else begin
            if (ecl) m_clo = m_lo;
            if (ech) m_chi = m_hi;
            if (mchg || !run_lo) m_lo = '0;
            else if (ptick) begin
                if (m_lo == match_lo) begin m_lo = '0; fl = 1'b1; end
                else m_lo = m_lo + 8'd1;
            end
            adv = (mode == 2'd0) ? ptick : ev;
            if (mchg || !run_hi) m_hi = '0;
            else if (adv) begin
                if (m_hi == match_hi) begin m_hi = '0; fh = 1'b1; end
                else m_hi = m_hi + 8'd1;
            end
        end
        m_evt   = {m_evt[1:0], evt_pin};
        m_clo_s = {m_clo_s[1:0], cap_lo_pin};
        m_chi_s = {m_chi_s[1:0], cap_hi_pin};
        m_mode  = mode;
        e.lo = m_lo; e.hi = m_hi; e.clo = m_clo; e.chi = m_chi;
        e.fl = fl; e.fh = fh; e.tag = tag;
        sb_q.push_back(e);
        cyc_en = 1'b1;
        @(negedge clk) cyc_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // pin held high for one tick, then low for one tick
    task automatic pulse(input int which, input string tag);
        if (which == 0) evt_pin = 1'b1;
        else if (which == 1) cap_lo_pin = 1'b1;
        else cap_hi_pin = 1'b1;
        tick(tag);
        evt_pin = 1'b0; cap_lo_pin = 1'b0; cap_hi_pin = 1'b0;
        tick(tag);
    endtask

    // rises and falls between two ticks
    task automatic glitch();
        evt_pin = 1'b1; cap_lo_pin = 1'b1; cap_hi_pin = 1'b1;
        @(negedge clk);
        evt_pin = 1'b0; cap_lo_pin = 1'b0; cap_hi_pin = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compare each tick's result one clock after it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (cyc_en) begin
                @(negedge clk);
                e = sb_q.pop_front();
                checks++;
                if (cnt_lo !== e.lo || cnt_hi !== e.hi || cap_lo !== e.clo ||
                    cap_hi !== e.chi || flag_lo !== e.fl || flag_hi !== e.fh) begin
                    errors++;
                    $display("FAIL %s: got lo=%h hi=%h clo=%h chi=%h fl=%b fh=%b exp lo=%h hi=%h clo=%h chi=%h fl=%b fh=%b",
                             e.tag, cnt_lo, cnt_hi, cap_lo, cap_hi, flag_lo, flag_hi,
                             e.lo, e.hi, e.clo, e.chi, e.fl, e.fh);
                end
                @(negedge clk);
                checks++;
                if (flag_lo !== 1'b0 || flag_hi !== 1'b0) begin
                    errors++;
                    $display("FAIL R8 flag width: got fl=%b fh=%b exp 0 0", flag_lo, flag_hi);
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if ({cnt_lo, cnt_hi, cap_lo, cap_hi, flag_lo, flag_hi} !== '0) begin
            errors++;
            $display("FAIL R1: got %h %h %h %h %b %b exp all zero",
                     cnt_lo, cnt_hi, cap_lo, cap_hi, flag_lo, flag_hi);
        end

        // R4 / R8 split mode, two prescaled halves
        mode = 2'd0; match_lo = 8'd5; match_hi = 8'd2; pre_reload = 8'd1;
        run_lo = 1'b1; run_hi = 1'b1;
        ticks(30, "R4");
        // R3 new reload at next wrap
        pre_reload = 8'd3;
        ticks(24, "R3");
        // R9 captures in split mode
        pulse(1, "R9");
        ticks(3, "R9");
        pulse(2, "R9");
        ticks(3, "R9");
        // R11 low half stopped, captures kept
        run_lo = 1'b0;
        ticks(6, "R11");
        run_lo = 1'b1;
        ticks(5, "R4");

        // R5 mixed mode, high half counts events
        mode = 2'd1; match_lo = 8'd3; match_hi = 8'd4; pre_reload = 8'd0;
        for (int i = 0; i < 8; i++) pulse(0, "R5");
        ticks(3, "R5");
        // R2 short pulses between ticks are ignored
        for (int i = 0; i < 4; i++) begin
            glitch();
            tick("R2");
        end
        ticks(3, "R2");

        // R6 16-bit prescaled timer with carry
        mode = 2'd2; match_lo = 8'd5; match_hi = 8'd1; pre_reload = 8'd0;
        run_lo = 1'b0;
        ticks(270, "R6");
        // R10 low strobe ignored, high strobe captures 16 bits
        pulse(1, "R10");
        ticks(3, "R10");
        pulse(2, "R10");
        ticks(3, "R10");

        // R7 16-bit event counter
        mode = 2'd3; match_lo = 8'd3; match_hi = 8'd0;
        for (int i = 0; i < 10; i++) pulse(0, "R7");
        ticks(3, "R7");
        pulse(2, "R10");
        ticks(3, "R10");
        // R11 mode change clears counts, keeps captures
        mode = 2'd0; pre_reload = 8'd2;
        ticks(8, "R11");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule